// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block models a small field-configurable logic device. A programmable AND plane forms product terms from eight dedicated inputs and eight feedback signals, each signal available in true and complement form. A fixed OR stage sums the product terms that belong to each of eight output cells. Each cell can be set up as a clocked flip-flop path or a direct combinational path, with its own output polarity and its own source for the output enable.

All configuration (AND-plane connections, two device-wide mode bits, one mode bit and one polarity bit per cell) is held in a single serial chain. The chain is loaded most-significant bit first while the program input is high. During loading, the outputs are released and the cell flip-flops keep their values. A preload input writes arbitrary values into the cell flip-flops for test. The reset input clears the flip-flops and the configuration.

Top module: `sop_logic_array`

## Requirements
- R1: A product term is 1 only when at least one literal is connected and every connected literal is 1. A term with nothing connected reads 0, and so does a term that has both the true and the complement literal of the same signal connected. The literal fuse for term t of cell c on signal k sits at config bit (c*8+t)*32 + 2k for the true form and 2k+1 for the complement form. Signals 0..7 are `din[0..7]` and signals 8..15 are the feedback of cells 0..7.
- R2: A cell's sum is the OR of its eight terms. The exception is a combinational cell while the device bit `pt_oe` is 1: its sum is the OR of terms 1..7 only.
- R3: The polarity bit of cell c is config bit 2048+c. When it is 1 the cell presents its sum. When it is 0 the cell presents the inverted sum. This holds on both cell paths, and after reset with an empty array every output reads 1.
- R4: A registered cell loads its polarity-adjusted sum on the rising clock edge, and its pin shows the flip-flop. Its output enable equals the inverse of `pin_oe_n`.
- R5: A registered cell feeds the inverted flip-flop back into the array. A combinational cell feeds back its `io_in` pin value.
- R6: A cell is registered only when device bit `reg_en` (config bit 2065) and the cell's local bit (config bit 2056+c) are both 1. Otherwise it is combinational. Cells may be mixed freely.
- R7: While `prog_en` is high, each clock shifts `prog_sdi` into the chain at bit 0. A frame of 2066 bits sent most-significant first lands bit i of the frame at config bit i. The configuration does not change while `prog_en` is low.
- R8: While `prog_en` is high, every output enable is 0, the cell flip-flops hold their values and preload is ignored.
- R9: An active-low `rst_n` asynchronously clears all cell flip-flops and the whole configuration.
- R10: When `preload_en` is high at a clock edge outside programming, every cell flip-flop loads its bit of `preload_val`. This takes priority over the normal capture.
- R11: A combinational cell's output enable is its term 0 when `pt_oe` (config bit 2064) is 1, and is always 1 when `pt_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for cell flip-flops and config chain |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Configuration shift enable; suspends logic |
| prog_sdi | input | 1 | Serial configuration data |
| pin_oe_n | input | 1 | Shared active-low enable for registered cells |
| preload_en | input | 1 | Load flip-flops from preload_val |
| preload_val | input | 8 | Preload values, one bit per cell |
| din | input | 8 | Dedicated logic inputs |
| io_in | input | 8 | Values seen on the I/O pins |
| io_out | output | 8 | Values driven toward the I/O pins |
| io_oe | output | 8 | Per-pin drive enables |

## Verification
There are two pairs of functions that can fall in the same cycle. First, preload and normal capture: the bench raises `preload_en` at an edge where the inputs would capture the opposite value, and judges the result by which value appears on the registered pins. Second, programming and preload: `preload_en` is held high with zero data during a whole configuration load. The bench then checks that every output enable stayed low mid-load, and that the previously preloaded pattern is still on the pins once loading ends.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef struct packed {
    logic reg_en;  // allows registered cells
    logic pt_oe;   // combinational cells use term 0 as enable
  } glob_cfg_t;

  typedef enum logic {
    CELL_COMB = 1'b0,
    CELL_REG  = 1'b1
  } cell_mode_e;
endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
  parameter int CFG_W = 2066
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             sdi,
  output logic [CFG_W-1:0] cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg <= '0;
    else if (shift_en) cfg <= {cfg[CFG_W-2:0], sdi};
  end

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> cfg[0] == $past(sdi)); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(cfg)); // R7
endmodule

// File: rtl/sop_and_array.sv
module sop_and_array #(
  parameter int N_SIG  = 16,
  parameter int N_TERM = 64,
  localparam int LIT_W  = 2 * N_SIG,
  localparam int FUSE_W = N_TERM * LIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SIG-1:0]  sig,
  input  logic [FUSE_W-1:0] fuses,
  output logic [N_TERM-1:0] term
);
  // even position: true literal, odd position: complement literal
  function automatic logic [LIT_W-1:0] make_lits(input logic [N_SIG-1:0] s);
    logic [LIT_W-1:0] r;
    for (int k = 0; k < N_SIG; k++) begin
      r[2*k]   = s[k];
      r[2*k+1] = ~s[k];
    end
    return r;
  endfunction

  function automatic logic eval_term(input logic [LIT_W-1:0] f,
                                     input logic [LIT_W-1:0] l);
    return (|f) & (&(l | ~f));
  endfunction

  function automatic logic dual_lit(input logic [LIT_W-1:0] f);
    logic c;
    c = 1'b0;
    for (int k = 0; k < N_SIG; k++) c = c | (f[2*k] & f[2*k+1]);
    return c;
  endfunction

  logic [LIT_W-1:0] lits;
  assign lits = make_lits(sig);

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [LIT_W-1:0] f_t;
    logic             conflict;
    logic             empty;
    assign f_t      = fuses[t*LIT_W +: LIT_W];
    assign term[t]  = eval_term(f_t, lits);
    assign conflict = dual_lit(f_t);
    assign empty    = (f_t == '0);

    AST_DUAL_LIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      conflict |-> !term[t]); // R1
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !term[t]); // R1
  end
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import sop_pkg::*;
#(
  parameter int N_PT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            preload_en,
  input  logic            preload_bit,
  input  logic [N_PT-1:0] terms,
  input  glob_cfg_t       glob,
  input  logic            local_bit,
  input  logic            pol_bit,
  input  logic            oe_pin_n,
  input  logic            pin_in,
  output logic            pin_out,
  output logic            pin_oe,
  output logic            fb
);
  cell_mode_e mode;
  logic       use_pt_oe;
  logic       sum;
  logic       d;
  logic       q;
  logic       capture_ev;
  logic       preload_ev;

  assign mode      = (glob.reg_en & local_bit) ? CELL_REG : CELL_COMB;
  assign use_pt_oe = (mode == CELL_COMB) & glob.pt_oe;
  assign sum       = use_pt_oe ? |terms[N_PT-1:1] : |terms;
  assign d         = sum ^ ~pol_bit;

  assign preload_ev = !hold & preload_en;
  assign capture_ev = !hold & !preload_en & (mode == CELL_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= 1'b0;
    else if (preload_ev) q <= preload_bit;
    else if (capture_ev) q <= d;
  end

  always_comb begin
    if (hold)                  pin_oe = 1'b0;
    else if (mode == CELL_REG) pin_oe = ~oe_pin_n;
    else if (use_pt_oe)        pin_oe = terms[0];
    else                       pin_oe = 1'b1;
  end

  assign pin_out = (mode == CELL_REG) ? q : d;
  assign fb      = (mode == CELL_REG) ? ~q : pin_in;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(q)); // R8
  AST_HOLD_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !pin_oe); // R8
  AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    preload_ev |=> q == $past(preload_bit)); // R10
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture_ev |=> q == $past(d)); // R4
  AST_REG_FB_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CELL_REG) |-> fb != pin_out); // R5
  AST_COMB_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == CELL_COMB) && !glob.pt_oe && !hold) |-> pin_oe); // R11
  AST_RESET_CLR: assert property (@(posedge clk)
    !rst_n |-> q == 1'b0); // R9
endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
  import sop_pkg::*;
#(
  parameter int DIN_W  = 8,
  parameter int CELLS  = 8,
  parameter int PTERMS = 8,
  localparam int SIG_W  = DIN_W + CELLS,
  localparam int LIT_W  = 2 * SIG_W,
  localparam int TERM_N = CELLS * PTERMS,
  localparam int FUSE_W = TERM_N * LIT_W,
  localparam int CFG_W  = FUSE_W + 2 * CELLS + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_en,
  input  logic             prog_sdi,
  input  logic             pin_oe_n,
  input  logic             preload_en,
  input  logic [CELLS-1:0] preload_val,
  input  logic [DIN_W-1:0] din,
  input  logic [CELLS-1:0] io_in,
  output logic [CELLS-1:0] io_out,
  output logic [CELLS-1:0] io_oe
);
  logic [CFG_W-1:0]  cfg;
  glob_cfg_t         glob;
  logic [CELLS-1:0]  local_bits;
  logic [CELLS-1:0]  pol_bits;
  logic [FUSE_W-1:0] fuses;
  logic [CELLS-1:0]  fb;
  logic [SIG_W-1:0]  sig;
  logic [TERM_N-1:0] terms;

  sop_cfg_chain #(.CFG_W(CFG_W)) i_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (prog_en),
    .sdi      (prog_sdi),
    .cfg      (cfg)
  );

  assign glob       = glob_cfg_t'(cfg[CFG_W-1 -: 2]);
  assign local_bits = cfg[FUSE_W+CELLS +: CELLS];
  assign pol_bits   = cfg[FUSE_W +: CELLS];
  assign fuses      = cfg[FUSE_W-1:0];
  assign sig        = {fb, din};

  sop_and_array #(.N_SIG(SIG_W), .N_TERM(TERM_N)) i_array (
    .clk   (clk),
    .rst_n (rst_n),
    .sig   (sig),
    .fuses (fuses),
    .term  (terms)
  );

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    sop_macrocell #(.N_PT(PTERMS)) i_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold        (prog_en),
      .preload_en  (preload_en),
      .preload_bit (preload_val[c]),
      .terms       (terms[c*PTERMS +: PTERMS]),
      .glob        (glob),
      .local_bit   (local_bits[c]),
      .pol_bit     (pol_bits[c]),
      .oe_pin_n    (pin_oe_n),
      .pin_in      (io_in[c]),
      .pin_out     (io_out[c]),
      .pin_oe      (io_oe[c]),
      .fb          (fb[c])
    );
  end

  AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> io_oe == '0); // R8
endmodule

// File: tb/test_sop_logic_array.sv
module test_sop_logic_array;
  localparam int CFG_W  = 2066;
  localparam int FUSE_W = 2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_en = 1'b0;
  logic       prog_sdi = 1'b0;
  logic       pin_oe_n = 1'b1;
  logic       preload_en = 1'b0;
  logic [7:0] preload_val = '0;
  logic [7:0] din = '0;
  logic [7:0] io_in = '0;
  logic [7:0] io_out;
  logic [7:0] io_oe;

  logic [CFG_W-1:0] cfg_tb;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sop_logic_array i_sop_logic_array (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_sdi(prog_sdi),
    .pin_oe_n(pin_oe_n), .preload_en(preload_en), .preload_val(preload_val),
    .din(din), .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    din = '0; io_in = '0; preload_en = 1'b0; pin_oe_n = 1'b1;
    tick();
    rst_n = 1'b1;
  endtask

  task automatic cfg_clear();
    cfg_tb = '0;
  endtask

  task automatic connect(input int c, input int t, input int k, input bit neg);
    cfg_tb[(c*8+t)*32 + 2*k + int'(neg)] = 1'b1;
  endtask

  task automatic set_glob(input bit reg_en, input bit pt_oe);
    cfg_tb[CFG_W-1] = reg_en;
    cfg_tb[CFG_W-2] = pt_oe;
  endtask

  task automatic set_cell(input int c, input bit loc, input bit pol);
    cfg_tb[FUSE_W+8+c] = loc;
    cfg_tb[FUSE_W+c]   = pol;
  endtask

  // frame sent most significant bit first; optional mid-load enable check
  task automatic load_cfg(input bit probe);
    prog_en = 1'b1;
    for (int i = CFG_W-1; i >= 0; i--) begin
      prog_sdi = cfg_tb[i];
      if (probe && i == CFG_W/2) begin
        #1 check("R8 oe during load", io_oe, 8'h00);
      end
      @(negedge clk);
    end
    prog_en = 1'b0;
    prog_sdi = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R9 reset oe", io_oe, 8'hFF);
    check("R3 reset out inverted empty sum", io_out, 8'hFF);
  endtask

  task automatic t_comb();
    logic [7:0] pats [7];
    logic [7:0] d;
    logic [7:0] exp;
    pats = '{8'h01, 8'h03, 8'h18, 8'h20, 8'h08, 8'h04, 8'h00};
    do_reset();
    cfg_clear();
    set_glob(1'b0, 1'b0);
    set_cell(0, 1'b1, 1'b1);                    // local=1 but reg_en=0: R6
    connect(0, 0, 0, 1'b0); connect(0, 0, 1, 1'b1);
    set_cell(1, 1'b0, 1'b1);
    connect(1, 1, 2, 1'b0); connect(1, 1, 2, 1'b1);
    set_cell(2, 1'b0, 1'b1);
    connect(2, 3, 3, 1'b0); connect(2, 5, 4, 1'b0);
    set_cell(3, 1'b0, 1'b0);
    connect(3, 0, 5, 1'b0);
    for (int c = 4; c < 8; c++) set_cell(c, 1'b0, 1'b1);
    load_cfg(1'b0);
    for (int i = 0; i < 7; i++) begin
      d = pats[i];
      din = d;
      #1;
      exp = {4'b0000, ~d[5], d[3] | d[4], 1'b0, d[0] & ~d[1]};
      check("R1 R2 R3 R6 combinational sum", io_out, exp);
      @(negedge clk);
    end
    check("R11 comb enable always on", io_oe, 8'hFF);
  endtask

  task automatic t_ptoe();
    logic [7:0] pats [3];
    pats = '{8'h00, 8'h40, 8'hC0};
    do_reset();
    cfg_clear();
    set_glob(1'b0, 1'b1);
    for (int c = 0; c < 8; c++) set_cell(c, 1'b0, 1'b1);
    connect(0, 0, 6, 1'b0);
    connect(0, 1, 7, 1'b0);
    load_cfg(1'b0);
    for (int i = 0; i < 3; i++) begin
      din = pats[i];
      #1;
      check("R11 term0 enable", io_oe, {7'b0, pats[i][6]});
      check("R2 term0 excluded from sum", {7'b0, io_out[0]}, {7'b0, pats[i][7]});
      @(negedge clk);
    end
  endtask

  task automatic reg_cfg();
    cfg_clear();
    set_glob(1'b1, 1'b0);
    set_cell(0, 1'b1, 1'b1); connect(0, 0, 0, 1'b0);
    set_cell(1, 1'b1, 1'b0); connect(1, 0, 0, 1'b0);
    set_cell(2, 1'b0, 1'b1); connect(2, 0, 1, 1'b0);
    set_cell(3, 1'b1, 1'b1); connect(3, 0, 11, 1'b0);
    set_cell(4, 1'b0, 1'b1); connect(4, 0, 12, 1'b0);
  endtask

  task automatic t_reg();
    do_reset();
    reg_cfg();
    load_cfg(1'b0);
    #1 check("R4 R6 shared enable off", io_oe, 8'hF4);
    pin_oe_n = 1'b0;
    #1 check("R4 shared enable on", io_oe, 8'hFF);
    din = 8'h01;
    #1 check("R4 no change before edge", io_out, 8'hE0);
    tick();
    check("R4 R3 R5 capture and toggle", io_out, 8'hE9);
    din = 8'h00;
    tick();
    check("R5 registered feedback toggles", io_out, 8'hE2);
    din = 8'h02; io_in = 8'h10;
    #1 check("R5 pin feedback", io_out, 8'hF6);
  endtask

  task automatic t_preload();
    do_reset();
    reg_cfg();
    load_cfg(1'b0);
    pin_oe_n = 1'b0;
    din = 8'h01;
    preload_val = 8'h0A;
    preload_en = 1'b1;
    tick();
    preload_en = 1'b0;
    check("R10 preload beats capture", io_out, 8'hEA);
    tick();
    check("R10 normal capture resumes", io_out, 8'hE1);
  endtask

  task automatic t_prog();
    do_reset();
    reg_cfg();
    load_cfg(1'b0);
    pin_oe_n = 1'b0;
    preload_val = 8'h0B;
    preload_en = 1'b1;
    tick();
    check("R10 preload pattern", io_out, 8'hEB);
    preload_val = 8'h00;
    din = 8'h00;
    load_cfg(1'b1);
    preload_en = 1'b0;
    #1;
    check("R8 flip-flops held through load", io_out, 8'hEB);
    check("R7 reloaded config enables", io_oe, 8'hFF);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check("R9 async clear of config", io_out, 8'hFF);
    check("R9 async clear enables", io_oe, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    din = '0; io_in = '0;
    reg_cfg();
    load_cfg(1'b0);
    #1 check("R9 flip-flops cleared", io_out, 8'hE0);
  endtask

  initial begin
    t_reset();
    t_comb();
    t_ptoe();
    t_reg();
    t_preload();
    t_prog();
    t_reset_mid();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule